// File: doc/BRIEF.md
# Idle Power-Down Manager for a Multi-Bank Flash Subsystem

This block decides when the supply of a flash subsystem is on. A host asks for access with a request line. If the supply is off at that moment, the block switches it on, releases the parked pins and starts the controller clock. It then waits a fixed settling time and resets, one at a time, every bank that is marked present. Only after that does it grant the access. While the supply is on, each grant and each completion records the current time as the moment of last activity.

A coarse periodic check runs at a fixed rate. When a check finds the supply on, no access open or pending, and more idle time than the limit since the last activity, the supply goes off. In the same cycle the pins are parked low and the controller clock is gated. If a bank reports a failed reset while powering up, the block stops in a fatal state. It names the failing bank and never grants access again until reset.

The present-bank mask is loaded by an initialisation strobe. Until that strobe arrives the mask is empty, so a power-up done during initialisation resets no bank. Time is counted in ticks of a parameterised cycle prescaler.

Top module: `flash_pwr_mgr`

## Requirements
- R1: After reset the supply is off, the pins are parked, the controller clock is gated, access is not ready, no bank reset is requested, no fatal error is flagged and the present mask is empty.
- R2: A request while the supply is off turns the supply and controller clock on and releases the pins in the next cycle. Ready and grant stay low for the whole settle and bank-reset sequence.
- R3: The first bank reset request comes after exactly SETTLE_TICKS*TICK_CYCLES cycles with the supply on, plus one cycle for each absent bank of lower index that is skipped.
- R4: Bank resets are requested one at a time, in ascending bank index, only for banks marked present. Each request (bit b of the reset vector for bank b) is held until it is acknowledged.
- R5: The present mask is taken from the mask input when the load strobe is high. With an empty mask a power-up requests no reset and becomes ready NUM_BANKS cycles after settling.
- R6: An acknowledge with the fail flag set makes the fatal output high and keeps it high. It reports the failing bank index, keeps the supply on and never grants access again.
- R7: When ready, a grant is given in the same cycle as the request, provided no access is open. While an access is open (from grant until the done strobe) no further grant is given.
- R8: Each grant and each done strobe records the current tick as the last activity. The supply is never switched off before more than IDLE_TICKS full ticks have elapsed since then.
- R9: Idleness is examined only on a check event every CHECK_TICKS ticks. The supply goes off no later than (IDLE_TICKS+CHECK_TICKS+2)*TICK_CYCLES cycles after the last activity.
- R10: The supply is never switched off while an access is open, however long it lasts.
- R11: Switching off drops the supply, parks the pins, gates the clock and clears ready together. Check events while off change nothing.
- R12: A request after a power-down repeats the full settle and reset sequence before the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_load | input | 1 | Strobe that loads the present-bank mask |
| init_mask | input | NUM_BANKS | Present-bank mask, bit b for bank b |
| acc_req | input | 1 | Host access request, held until granted |
| acc_done | input | 1 | One-cycle strobe marking the end of the open access |
| acc_gnt | output | 1 | Access granted this cycle |
| acc_ready | output | 1 | Subsystem powered and reset, accesses can be granted |
| rst_req | output | NUM_BANKS | One-hot bank reset request |
| rst_ack | input | 1 | Reset of the requested bank finished |
| rst_fail | input | 1 | Qualifies rst_ack: the reset failed |
| supply_en | output | 1 | Supply enable to the regulator |
| pins_park | output | 1 | Drive flash pins as low outputs |
| ctl_clk_en | output | 1 | Controller clock enable |
| fatal_err | output | 1 | Sticky bank reset failure |
| fatal_bank | output | clog2(NUM_BANKS) | Index of the bank whose reset failed |

## Verification
The bench measures the settle gap for several masks. A design that counts the delay in ticks with a free-running phase, or that does not skip absent banks cycle by cycle, would miss the exact count. A scoreboard of expected bank indices catches resets to absent banks, resets out of order, and resets sent during the initial empty-mask power-up. The idle window is checked from both sides: an early switch-off, or one made without waiting for a check event, fails the lower bound, and a missed check fails the upper bound. A long open access and a failed reset on a middle bank catch designs that power down under an active host, or that keep resetting and grant after a fatal error.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [2:0] {
    PS_OFF    = 3'd0,
    PS_SETTLE = 3'd1,
    PS_RESET  = 3'd2,
    PS_ON     = 3'd3,
    PS_FAULT  = 3'd4
  } pwr_state_t;

  // Strictly greater: the idle limit must be exceeded, not just reached.
  function automatic logic beyond_limit(input logic [31:0] elapsed,
                                        input logic [31:0] limit);
    return elapsed > limit;
  endfunction

  // Settling delay expressed in raw clock cycles.
  function automatic int unsigned settle_len(input int unsigned ticks,
                                             input int unsigned cyc_per_tick);
    return ticks * cyc_per_tick;
  endfunction

  // Ticks between two modular timestamps.
  function automatic logic [31:0] tick_gap(input logic [31:0] now_t,
                                           input logic [31:0] then_t,
                                           input int unsigned width);
    logic [31:0] mask;
    mask = (width >= 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 32'd1);
    return (now_t - then_t) & mask;
  endfunction

endpackage

// File: rtl/fpm_timebase.sv
module fpm_timebase #(
  parameter int unsigned TICK_CYCLES = 125000,
  parameter int unsigned CHECK_TICKS = 100,
  parameter int unsigned TS_W        = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            check_evt,
  output logic [TS_W-1:0] now
);
  localparam int unsigned CHK_W = (CHECK_TICKS > 1) ? $clog2(CHECK_TICKS + 1) : 1;

  logic            tick;
  logic [CHK_W-1:0] chk_q;
  logic [TS_W-1:0]  now_q;

  generate
    if (TICK_CYCLES > 1) begin : g_prescale
      localparam int unsigned PRE_W = $clog2(TICK_CYCLES);
      logic [PRE_W-1:0] pre_q;
      assign tick = (pre_q == PRE_W'(TICK_CYCLES - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pre_q <= '0;
        else if (tick)  pre_q <= '0;
        else            pre_q <= pre_q + 1'b1;
      end
    end else begin : g_every_cycle
      assign tick = 1'b1;
    end
  endgenerate

  assign check_evt = tick && (chk_q == CHK_W'(CHECK_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_q <= '0;
      now_q <= '0;
    end else if (tick) begin
      chk_q <= check_evt ? '0 : chk_q + 1'b1;
      now_q <= now_q + 1'b1;
    end
  end

  assign now = now_q;
endmodule

// File: rtl/fpm_bank_seq.sv
module fpm_bank_seq #(
  parameter int unsigned NB = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 start,
  input  logic [NB-1:0]                        mask,
  input  logic                                 rst_ack,
  input  logic                                 rst_fail,
  output logic [NB-1:0]                        rst_req,
  output logic [NB-1:0]                        snap,
  output logic                                 done,
  output logic                                 fail,
  output logic [((NB > 1) ? $clog2(NB) : 1)-1:0] fail_idx
);
  localparam int unsigned IDX_W = (NB > 1) ? $clog2(NB) : 1;

  logic             active_q;
  logic [IDX_W-1:0] idx_q;
  logic [NB-1:0]    snap_q;
  logic             cur_present;
  logic             at_last;
  logic             advance;

  assign cur_present = snap_q[idx_q];
  assign at_last     = (idx_q == IDX_W'(NB - 1));
  assign advance     = active_q && (!cur_present || (rst_ack && !rst_fail));
  assign done        = advance && at_last;
  assign fail        = active_q && cur_present && rst_ack && rst_fail;
  assign fail_idx    = idx_q;
  assign snap        = snap_q;

  generate
    for (genvar b = 0; b < NB; b++) begin : g_req
      assign rst_req[b] = active_q && snap_q[b] && (idx_q == IDX_W'(b));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      snap_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      snap_q   <= mask;
    end else if (fail) begin
      active_q <= 1'b0;
    end else if (advance) begin
      if (at_last) active_q <= 1'b0;
      else         idx_q    <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/flash_pwr_mgr.sv
module flash_pwr_mgr #(
  parameter int unsigned NUM_BANKS    = 4,
  parameter int unsigned TICK_CYCLES  = 125000,
  parameter int unsigned SETTLE_TICKS = 50,
  parameter int unsigned CHECK_TICKS  = 100,
  parameter int unsigned IDLE_TICKS   = 200
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init_load,
  input  logic [NUM_BANKS-1:0] init_mask,
  input  logic                 acc_req,
  input  logic                 acc_done,
  output logic                 acc_gnt,
  output logic                 acc_ready,
  output logic [NUM_BANKS-1:0] rst_req,
  input  logic                 rst_ack,
  input  logic                 rst_fail,
  output logic                 supply_en,
  output logic                 pins_park,
  output logic                 ctl_clk_en,
  output logic                 fatal_err,
  output logic [((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1)-1:0] fatal_bank
);
  import fpm_pkg::*;

  localparam int unsigned IDX_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int unsigned TS_W       = $clog2(IDLE_TICKS + 2 * CHECK_TICKS + 2) + 1;
  localparam int unsigned SETTLE_CYC = settle_len(SETTLE_TICKS, TICK_CYCLES);
  localparam int unsigned SC_W       = $clog2(SETTLE_CYC + 1);

  pwr_state_t           state_q;
  logic [SC_W-1:0]      settle_q;
  logic                 busy_q;
  logic [NUM_BANKS-1:0] present_q;
  logic [TS_W-1:0]      last_q;
  logic [IDX_W-1:0]     fatal_bank_q;

  // Internal events, named so the checker can observe them.
  logic                 check_evt;
  logic [TS_W-1:0]      now;
  logic                 seq_start;
  logic                 seq_done;
  logic                 seq_fail;
  logic [IDX_W-1:0]     seq_fail_idx;
  logic [NUM_BANKS-1:0] seq_snap;
  logic                 stamp;
  logic                 idle_over;
  logic                 settle_end;
  logic                 pd_go;

  fpm_timebase #(
    .TICK_CYCLES (TICK_CYCLES),
    .CHECK_TICKS (CHECK_TICKS),
    .TS_W        (TS_W)
  ) u_timebase (
    .clk       (clk),
    .rst_n     (rst_n),
    .check_evt (check_evt),
    .now       (now)
  );

  fpm_bank_seq #(
    .NB (NUM_BANKS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (seq_start),
    .mask     (present_q),
    .rst_ack  (rst_ack),
    .rst_fail (rst_fail),
    .rst_req  (rst_req),
    .snap     (seq_snap),
    .done     (seq_done),
    .fail     (seq_fail),
    .fail_idx (seq_fail_idx)
  );

  assign acc_gnt    = (state_q == PS_ON) && acc_req && !busy_q;
  assign stamp      = acc_gnt || (busy_q && acc_done) || seq_done;
  assign idle_over  = beyond_limit(tick_gap(32'(now), 32'(last_q), TS_W),
                                   32'(IDLE_TICKS));
  assign settle_end = (state_q == PS_SETTLE) && (settle_q == SC_W'(SETTLE_CYC - 1));
  assign seq_start  = settle_end;
  assign pd_go      = check_evt && (state_q == PS_ON) && !busy_q && !acc_req && idle_over;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= PS_OFF;
      settle_q     <= '0;
      fatal_bank_q <= '0;
    end else begin
      unique case (state_q)
        PS_OFF: begin
          if (acc_req) begin
            state_q  <= PS_SETTLE;
            settle_q <= '0;
          end
        end
        PS_SETTLE: begin
          settle_q <= settle_q + 1'b1;
          if (settle_end) state_q <= PS_RESET;
        end
        PS_RESET: begin
          if (seq_fail) begin
            state_q      <= PS_FAULT;
            fatal_bank_q <= seq_fail_idx;
          end else if (seq_done) begin
            state_q <= PS_ON;
          end
        end
        PS_ON: begin
          if (pd_go) state_q <= PS_OFF;
        end
        PS_FAULT: state_q <= PS_FAULT;
        default:  state_q <= PS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy_q <= 1'b0;
    else if (acc_gnt)   busy_q <= 1'b1;
    else if (acc_done)  busy_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          present_q <= '0;
    else if (init_load)  present_q <= init_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_q <= '0;
    else if (stamp)  last_q <= now;
  end

  assign supply_en  = (state_q != PS_OFF);
  assign ctl_clk_en = (state_q != PS_OFF);
  assign pins_park  = (state_q == PS_OFF);
  assign acc_ready  = (state_q == PS_ON);
  assign fatal_err  = (state_q == PS_FAULT);
  assign fatal_bank = fatal_bank_q;
endmodule

// File: rtl/fpm_checker.sv
module fpm_checker #(
  parameter int unsigned NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          supply_en,
  input logic          pins_park,
  input logic          ctl_clk_en,
  input logic          acc_ready,
  input logic          acc_gnt,
  input logic          acc_busy,
  input logic [NB-1:0] rst_req,
  input logic          rst_ack,
  input logic          fatal_err,
  input logic          check_evt,
  input logic [NB-1:0] snap
);
  p_off_on_check_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(supply_en) |-> $past(check_evt));

  p_off_parked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_en |-> (pins_park && !ctl_clk_en && !acc_ready));

  p_grant_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_gnt |-> acc_ready);

  p_no_grant_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_busy |-> !acc_gnt);

  p_busy_keeps_power_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_busy |=> supply_en);

  p_one_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rst_req));

  p_reset_present_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req != '0) |-> ((rst_req & snap) == rst_req));

  p_reset_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((rst_req != '0) && !rst_ack) |=> (rst_req == $past(rst_req)));

  p_reset_powered_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req != '0) |-> (supply_en && !acc_ready));

  p_fatal_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_err |=> (fatal_err && !acc_gnt));
endmodule

bind flash_pwr_mgr fpm_checker #(.NB(NUM_BANKS)) u_fpm_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .supply_en  (supply_en),
  .pins_park  (pins_park),
  .ctl_clk_en (ctl_clk_en),
  .acc_ready  (acc_ready),
  .acc_gnt    (acc_gnt),
  .acc_busy   (busy_q),
  .rst_req    (rst_req),
  .rst_ack    (rst_ack),
  .fatal_err  (fatal_err),
  .check_evt  (check_evt),
  .snap       (seq_snap)
);

// File: tb/flash_pwr_mgr_test.sv
module flash_pwr_mgr_test;
  localparam int NB = 4;
  localparam int TC = 4;
  localparam int ST = 5;
  localparam int CT = 10;
  localparam int IT = 20;
  localparam int SC = ST * TC;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          init_load;
  logic [NB-1:0] init_mask;
  logic          acc_req;
  logic          acc_done;
  logic          acc_gnt;
  logic          acc_ready;
  logic [NB-1:0] rst_req;
  logic          rst_ack;
  logic          rst_fail;
  logic          supply_en;
  logic          pins_park;
  logic          ctl_clk_en;
  logic          fatal_err;
  logic [1:0]    fatal_bank;

  always #4 clk = ~clk;

  flash_pwr_mgr #(
    .NUM_BANKS    (NB),
    .TICK_CYCLES  (TC),
    .SETTLE_TICKS (ST),
    .CHECK_TICKS  (CT),
    .IDLE_TICKS   (IT)
  ) uut (
    .clk(clk), .rst_n(rst_n), .init_load(init_load), .init_mask(init_mask),
    .acc_req(acc_req), .acc_done(acc_done), .acc_gnt(acc_gnt), .acc_ready(acc_ready),
    .rst_req(rst_req), .rst_ack(rst_ack), .rst_fail(rst_fail),
    .supply_en(supply_en), .pins_park(pins_park), .ctl_clk_en(ctl_clk_en),
    .fatal_err(fatal_err), .fatal_bank(fatal_bank)
  );

  int checks   = 0;
  int fails    = 0;
  int fail_sel = -1;
  int exp_q[$];
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Expected settle gap: settle cycles plus one per skipped absent bank.
  function automatic int exp_gap(input logic [NB-1:0] m);
    for (int i = 0; i < NB; i++) if (m[i]) return SC + i;
    return SC + NB;
  endfunction

  // Driver side of the scoreboard: queue the banks that must be reset.
  task automatic push_banks(input logic [NB-1:0] m, input int stop_at);
    for (int i = 0; i < NB; i++)
      if (m[i] && (stop_at < 0 || i <= stop_at)) exp_q.push_back(i);
  endtask

  // Monitor and responder: pop the expected bank and acknowledge.
  initial begin
    int b;
    rst_ack  = 1'b0;
    rst_fail = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && rst_req != '0) begin
        b = -1;
        for (int i = 0; i < NB; i++) if (rst_req[i]) b = i;
        if (exp_q.size() == 0) chk(1'b0, "R4", "unexpected bank reset", b, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(b == e, "R4", "bank reset order", b, e);
        end
        repeat (2) @(negedge clk);
        rst_ack  = 1'b1;
        rst_fail = (b == fail_sel);
        @(negedge clk);
        rst_ack  = 1'b0;
        rst_fail = 1'b0;
      end
    end
  end

  // Raise a request while off and measure the gap before the first reset.
  task automatic start_power_up(input logic [NB-1:0] m, input string req);
    int  n;
    bit  early;
    @(negedge clk);
    acc_req = 1'b1;
    @(negedge clk);
    chk(supply_en && ctl_clk_en && !pins_park, "R2", "supply on after request",
        int'(supply_en), 1);
    n = 1;
    early = 1'b0;
    while (rst_req == '0 && !acc_ready && !fatal_err && n < 10000) begin
      if (acc_gnt || acc_ready) early = 1'b1;
      @(negedge clk);
      n++;
    end
    chk(!early, "R2", "ready withheld while settling", int'(early), 0);
    chk((n - 1) == exp_gap(m), req, "cycles before first reset or ready", n - 1, exp_gap(m));
  endtask

  task automatic take_grant(input string req);
    int n;
    n = 0;
    while (!acc_gnt && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(acc_gnt, req, "grant after power-up", int'(acc_gnt), 1);
    @(posedge clk);
    #1 acc_req = 1'b0;
    chk(exp_q.size() == 0, "R4", "all expected banks reset", exp_q.size(), 0);
  endtask

  task automatic finish_access();
    @(negedge clk);
    acc_done = 1'b1;
    @(posedge clk);
    #1 acc_done = 1'b0;
  endtask

  // Called just after the stamping edge.
  task automatic idle_window();
    repeat (IT * TC) @(posedge clk);
    @(negedge clk);
    chk(supply_en, "R8", "supply still on at idle limit", int'(supply_en), 1);
    repeat ((CT + 2) * TC) @(posedge clk);
    @(negedge clk);
    chk(!supply_en, "R9", "supply off after idle plus check period", int'(supply_en), 0);
    chk(pins_park && !ctl_clk_en && !acc_ready, "R11", "parked and gated when off",
        int'(pins_park), 1);
  endtask

  initial begin
    rst_n     = 1'b0;
    init_load = 1'b0;
    init_mask = '0;
    acc_req   = 1'b0;
    acc_done  = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!supply_en && pins_park && !ctl_clk_en, "R1", "power off after reset",
        int'(supply_en), 0);
    chk(!acc_ready && rst_req == '0 && !fatal_err && !acc_gnt, "R1", "idle outputs after reset",
        int'(rst_req), 0);

    repeat (3 * CT * TC) @(negedge clk);
    chk(!supply_en && pins_park, "R11", "check events while off do nothing",
        int'(supply_en), 0);

    // Power-up before the mask is loaded: no bank is reset (R5).
    start_power_up('0, "R5");
    take_grant("R5");
    finish_access();
    idle_window();

    repeat (2 * CT * TC) @(negedge clk);
    chk(!supply_en, "R11", "stays off across checks", int'(supply_en), 0);

    // Load a sparse mask and power up again (R12, R4, R3).
    @(negedge clk);
    init_load = 1'b1;
    init_mask = 4'b1010;
    @(negedge clk);
    init_load = 1'b0;
    push_banks(4'b1010, -1);
    start_power_up(4'b1010, "R3");
    take_grant("R12");

    // Second request during an open access is not granted (R7).
    @(negedge clk);
    acc_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!acc_gnt, "R7", "no grant while access open", int'(acc_gnt), 0);
    end
    acc_req = 1'b0;

    // Long access keeps power on (R10).
    repeat ((IT + 2 * CT) * TC) @(negedge clk);
    chk(supply_en && acc_ready, "R10", "power held during long access", int'(supply_en), 1);
    finish_access();
    idle_window();

    // Failed reset on bank 1 (R6).
    @(negedge clk);
    init_load = 1'b1;
    init_mask = 4'b0111;
    @(negedge clk);
    init_load = 1'b0;
    fail_sel = 1;
    push_banks(4'b0111, 1);
    start_power_up(4'b0111, "R3");
    for (int i = 0; i < 200 && !fatal_err; i++) @(negedge clk);
    chk(fatal_err, "R6", "fatal flagged", int'(fatal_err), 1);
    chk(int'(fatal_bank) == 1, "R6", "failing bank index", int'(fatal_bank), 1);
    begin
      bit got;
      got = 1'b0;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (acc_gnt || acc_ready) got = 1'b1;
      end
      chk(!got, "R6", "no grant after fatal", int'(got), 0);
    end
    chk(supply_en && fatal_err, "R6", "supply on and fatal held", int'(supply_en), 1);
    chk(exp_q.size() == 0, "R6", "no reset after failing bank", exp_q.size(), 0);
    acc_req = 1'b0;

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end
endmodule